// File: doc/BRIEF.md
# UART Transmit Holding and Shift Path

This block is the transmit half of a byte-oriented serial port. A processor writes one byte at a time over a parallel bus into a holding register. As soon as the serializer is free, the byte is copied into a shift register. The shift register sends it out on a single line as a low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts sixteen pulses of an oversampling tick, and that tick comes from a baud generator outside the block.

The holding register frees itself when its byte moves into the shift register, and not when the frame ends. Software can therefore queue the next byte while the current one is still on the line. When a byte is queued, the next frame starts immediately after the stop bit of the current one. The block reports two status flags, one for the holding register and one for the whole transmitter. It also drives an interrupt-condition output that tracks the holding-register flag.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, or after a reset applied in the middle of a frame, the line is 1, the holding-empty flag is 1, the transmitter-empty flag is 1 and the interrupt condition is 1.
- R2: A write pulse while the holding-empty flag is 1 captures the 8-bit bus value, and the holding-empty flag reads 0 in the following cycle.
- R3: The holding-empty flag returns to 1 in the cycle the held byte enters the shift register, while that byte's start bit is on the line.
- R4: A write while the holding-empty flag is 0 is ignored, and the byte already held is transmitted unchanged.
- R5: Each frame is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit, and each bit lasts 16 baud ticks.
- R6: The transmitter-empty flag is 1 only when the holding register is empty and no frame is being sent; the line is 1 whenever it is 1.
- R7: With nothing left to send, the line stays at 1 after the stop bit.
- R8: The line holds its value while the baud tick is low; bit timing advances only on ticks.
- R9: If a byte is held when a stop bit ends, its start bit follows at once with no idle bit between the frames.
- R10: The interrupt condition output equals the holding-empty flag at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| baud_tick | input | 1 | Oversampling tick, 16 per bit time |
| txd | output | 1 | Serial line, idle high |
| thr_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding and shift registers both idle |
| tx_irq_cond | output | 1 | Empty condition for interrupt logic |

## Verification
The framing is tried with all-zero, all-one, alternating and single-set-bit bytes at both ends. These patterns separate a reversed bit order, a missing shift and a stuck data bit, and they confirm the start and stop levels. A second byte is written while the first is still on the line, and a third write is attempted while the holding register is full. This shows whether the holding flag frees early, whether frames run back to back and whether a rejected write corrupts the held byte. Pausing the tick in the middle of a bit and resetting in the middle of a frame separate tick-gated timing from free-running timing and check the reset state.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } tx_phase_e;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (wr_en_i && !r_q.full) begin
            r_d.full = 1'b1;
            r_d.data = wr_data_i;
        end
        if (take_i) begin
            r_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign full_o = r_q.full;
    assign data_o = r_q.data;

    // R4: a write into a full holding register leaves the held byte alone
    p_hold_keep_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.full && wr_en_i) |=> (r_q.data == $past(r_q.data)));

    // R3: the shifter only takes a byte that is actually held
    p_take_legal_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> r_q.full);

    // R3: taking the byte frees the holding register next cycle
    p_take_frees_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !r_q.full);

    // R2: an accepted write makes the register full
    p_write_fills_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !r_q.full) |=> r_q.full);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick_i,
    input  logic              held_i,
    input  logic [DATA_W-1:0] held_data_i,
    output logic              take_o,
    output logic              busy_o,
    output logic              txd_o
);

    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        tx_phase_e         ph;
        logic [CNT_W-1:0]  tcnt;
        logic [IDX_W-1:0]  didx;
        logic [DATA_W-1:0] sreg;
    } shift_t;

    shift_t r_q, r_d;
    logic   bit_end;
    logic   do_load;

    always_comb begin
        r_d     = r_q;
        do_load = 1'b0;
        bit_end = baud_tick_i && (r_q.tcnt == CNT_LAST);

        if (r_q.ph != PH_IDLE && baud_tick_i) begin
            r_d.tcnt = bit_end ? '0 : r_q.tcnt + 1'b1;
        end

        unique case (r_q.ph)
            PH_IDLE: begin
                if (held_i) do_load = 1'b1;
            end
            PH_START: begin
                if (bit_end) begin
                    r_d.ph   = PH_DATA;
                    r_d.didx = '0;
                end
            end
            PH_DATA: begin
                if (bit_end) begin
                    r_d.sreg = r_q.sreg >> 1;
                    if (r_q.didx == IDX_LAST) begin
                        r_d.ph = PH_STOP;
                    end else begin
                        r_d.didx = r_q.didx + 1'b1;
                    end
                end
            end
            PH_STOP: begin
                if (bit_end) begin
                    if (held_i) do_load = 1'b1;
                    else        r_d.ph  = PH_IDLE;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase

        if (do_load) begin
            r_d.ph   = PH_START;
            r_d.tcnt = '0;
            r_d.didx = '0;
            r_d.sreg = held_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, tcnt: '0, didx: '0, sreg: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.ph)
            PH_START: txd_o = 1'b0;
            PH_DATA:  txd_o = r_q.sreg[0];
            default:  txd_o = 1'b1;
        endcase
    end

    assign take_o = do_load;
    assign busy_o = (r_q.ph != PH_IDLE);

    // R7: an idle serializer keeps the line high
    p_idle_high_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> txd_o);

    // R8: without a tick an active frame does not move
    p_tick_gate_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !baud_tick_i) |=> $stable(txd_o));

    // R9: every load puts a start bit on the line in the next cycle
    p_load_start_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !txd_o);

    // R5: the stop bit is high
    p_stop_high_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_STOP) |-> txd_o);

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              txd,
    output logic              thr_empty,
    output logic              tx_empty,
    output logic              tx_irq_cond
);

    logic              held;
    logic [DATA_W-1:0] held_data;
    logic              take;
    logic              busy;

    uart_tx_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .take_i    (take),
        .full_o    (held),
        .data_o    (held_data)
    );

    uart_tx_shift #(
        .DATA_W (DATA_W),
        .OVS    (OVS)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick_i (baud_tick),
        .held_i      (held),
        .held_data_i (held_data),
        .take_o      (take),
        .busy_o      (busy),
        .txd_o       (txd)
    );

    assign thr_empty   = !held;
    assign tx_empty    = !held && !busy;
    assign tx_irq_cond = !held;

    // R6: a fully empty transmitter has the line high
    p_empty_line_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    // R3: a held byte with a free serializer is taken in the same cycle
    p_no_stall_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (held && !busy) |=> (busy && !held) || !rst_n);

endmodule

// File: tb/sim_uart_tx_path.sv
module sim_uart_tx_path;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [7:0] data;
        logic [9:0] frame;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{data: 8'h00, frame: 10'b1000000000},
        '{data: 8'hFF, frame: 10'b1111111110},
        '{data: 8'hA5, frame: 10'b1101001010},
        '{data: 8'h3C, frame: 10'b1001111000},
        '{data: 8'h01, frame: 10'b1000000010},
        '{data: 8'h80, frame: 10'b1100000000}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       baud_tick;
    logic       tick_en;
    logic       txd, thr_empty, tx_empty, tx_irq_cond;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    uart_tx_path u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .baud_tick   (baud_tick),
        .txd         (txd),
        .thr_empty   (thr_empty),
        .tx_empty    (tx_empty),
        .tx_irq_cond (tx_irq_cond)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        baud_tick = 1'b0;
        forever begin
            @(negedge clk);
            baud_tick = tick_en ? ~baud_tick : 1'b0;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_start(input string req);
        int n = 0;
        while (txd !== 1'b0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, txd}, 32'd0);
    endtask

    // samples mid-bit: first after 'first' half-cycles-from-start negedges, then every bit time
    task automatic check_frame(input logic [9:0] exp, input int first, input string req);
        repeat (first) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            if (i != 0) repeat (32) @(negedge clk);
            chk($sformatf("%s bit%0d", req, i), {31'd0, txd}, {31'd0, exp[i]});
        end
    endtask

    task automatic wait_empty(input string req);
        int n = 0;
        while (tx_empty !== 1'b1 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, tx_empty}, 32'd1);
    endtask

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_data = 8'h00;
        tick_en = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 txd", {31'd0, txd}, 32'd1);
        chk("R1 thr_empty", {31'd0, thr_empty}, 32'd1);
        chk("R1 tx_empty", {31'd0, tx_empty}, 32'd1);
        chk("R1 irq", {31'd0, tx_irq_cond}, 32'd1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 idle line", {31'd0, txd}, 32'd1);

        // R5 framing over a table of bytes
        for (int v = 0; v < 6; v++) begin
            write_byte(VECS[v].data);
            chk("R2 thr_empty after write", {31'd0, thr_empty}, 32'd0);
            chk("R10 irq after write", {31'd0, tx_irq_cond}, 32'd0);
            wait_start("R5 start seen");
            chk("R3 thr_empty in start bit", {31'd0, thr_empty}, 32'd1);
            chk("R6 tx_empty while shifting", {31'd0, tx_empty}, 32'd0);
            check_frame(VECS[v].frame, 16, "R5 frame");
            wait_empty("R6 empty after frame");
            repeat (40) @(negedge clk);
            chk("R7 line high after frame", {31'd0, txd}, 32'd1);
        end

        // R9 back-to-back and R4 rejected write
        write_byte(8'hC3);
        wait_start("R9 first start");
        write_byte(8'h5A);
        chk("R2 second write taken", {31'd0, thr_empty}, 32'd0);
        chk("R10 irq with byte held", {31'd0, tx_irq_cond}, 32'd0);
        write_byte(8'hFF);
        chk("R4 still full", {31'd0, thr_empty}, 32'd0);
        check_frame(10'b1110000110, 14, "R9 frame A");
        check_frame(10'b1010110100, 32, "R4 R9 frame B");
        wait_empty("R6 empty after pair");
        repeat (400) @(negedge clk);
        chk("R4 no third frame", {31'd0, txd}, 32'd1);

        // R8 tick gating
        write_byte(8'h00);
        wait_start("R8 start");
        tick_en = 1'b0;
        repeat (300) @(negedge clk);
        chk("R8 line held", {31'd0, txd}, 32'd0);
        chk("R8 still busy", {31'd0, tx_empty}, 32'd0);
        tick_en = 1'b1;
        wait_empty("R8 frame completes");

        // R1 reset mid-frame
        write_byte(8'h55);
        wait_start("R1 start");
        repeat (100) @(negedge clk);
        write_byte(8'h12);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid txd", {31'd0, txd}, 32'd1);
        chk("R1 mid thr_empty", {31'd0, thr_empty}, 32'd1);
        chk("R1 mid tx_empty", {31'd0, tx_empty}, 32'd1);
        rst_n = 1'b1;
        repeat (400) @(negedge clk);
        chk("R7 quiet after reset", {31'd0, txd}, 32'd1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule